// File: doc/BRIEF.md
# Segment Translation Unit

This block turns a two-part logical address, a segment number plus an offset, into a physical address. It reads one entry of a small segment table held in registers. Each entry has a base address, a length limit, a presence flag and three access-permission flags. A length register sets how many segment numbers are legal.

Before the base is added to the offset, the block tests four fault conditions in a fixed order. Any fault replaces the translation with a nonzero error code. A configuration port writes table entries and the length register; each such write takes effect on the following cycle.

Requests enter on a valid/ready channel, and results leave on a second valid/ready channel one cycle after acceptance. Back-pressure rules:
- A request is accepted in a cycle when `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever the result slot is empty or is being drained in that same cycle.
- A result that is not taken stays on the outputs unchanged until `rsp_ready` is high.
- The configuration port has no handshake.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `rsp_valid` is low, `req_ready` is high, the length register is 0 and every entry is marked absent.
- R2: A request accepted at a clock edge (`req_valid && req_ready`) produces `rsp_valid` high after that edge. `req_ready` equals `!rsp_valid || rsp_ready`. With `rsp_ready` high and no new request, `rsp_valid` falls after the next edge.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rsp_err` and `rsp_pa` hold their values and no new request is accepted.
- R4: A segment number not strictly below the length register gives error code 1 (range).
- R5: A legal segment whose entry is absent gives error code 2 (absent).
- R6: An offset not strictly below the entry limit gives error code 3 (limit); a limit of 0 always faults.
- R7: Permission flags are bit 0 read, bit 1 write and bit 2 fetch. Access codes are 0 read, 1 write and 2 fetch; access code 3 is never permitted. An access without its flag gives error code 4 (permission).
- R8: When several faults apply, the lowest code in the order range, absent, limit, permission is reported.
- R9: A request with no fault gives error code 0 and a physical address equal to base plus offset, modulo 2^24.
- R10: Any faulted result carries a physical address of 0.
- R11: A table or length write issued in the same cycle as a request is not seen by that request; requests accepted on later cycles see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within segment |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 fetch) |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_pa | output | 24 | Physical address (0 on fault) |
| rsp_err | output | 3 | Error code, 0 success |
| cfg_ent_we | input | 1 | Write one table entry |
| cfg_ent_idx | input | 4 | Entry to write |
| cfg_base | input | 24 | Base written to entry |
| cfg_limit | input | 16 | Limit written to entry |
| cfg_present | input | 1 | Presence flag written to entry |
| cfg_perm | input | 3 | Permission flags written to entry |
| cfg_len_we | input | 1 | Write length register |
| cfg_len | input | 5 | New length value (0..16) |

## Verification
The assertions check the handshake on every cycle:
- an accepted request yields a result on the next cycle;
- a stalled result stays stable;
- `req_ready` follows the result slot;
- a faulted result carries address 0 and only defined codes appear;
- an out-of-range segment reports code 1.

Other behaviours need table contents known to the bench and come only from its scenarios:
- the absent, limit and permission codes and the order among them;
- the base-plus-offset sum, including wrap;
- a configuration write colliding with a request in the same cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_RANGE  = 3'd1,
    ERR_ABSENT = 3'd2,
    ERR_LIMIT  = 3'd3,
    ERR_PERM   = 3'd4
  } err_e;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W  = 4,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16,
  localparam int NSEG  = 1 << SEG_W,
  localparam int LEN_W = SEG_W + 1,
  localparam int PW    = seg_xlate_pkg::PERM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              wr_present,
  input  logic [PW-1:0]     wr_perm,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_d,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output logic              rd_present,
  output logic [PW-1:0]     rd_perm,
  output logic [LEN_W-1:0]  len_q
);
  logic [BASE_W-1:0] base_r  [NSEG];
  logic [LIM_W-1:0]  limit_r [NSEG];
  logic              pres_r  [NSEG];
  logic [PW-1:0]     perm_r  [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == SEG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_r[g]  <= '0;
        limit_r[g] <= '0;
        pres_r[g]  <= 1'b0;
        perm_r[g]  <= '0;
      end else if (hit) begin
        base_r[g]  <= wr_base;
        limit_r[g] <= wr_limit;
        pres_r[g]  <= wr_present;
        perm_r[g]  <= wr_perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_we) len_q <= len_d;
  end

  assign rd_base    = base_r[rd_idx];
  assign rd_limit   = limit_r[rd_idx];
  assign rd_present = pres_r[rd_idx];
  assign rd_perm    = perm_r[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16,
  localparam int LEN_W = SEG_W + 1,
  localparam int PW    = PERM_W
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [LIM_W-1:0]  off,
  input  logic [1:0]        acc,
  input  logic [LEN_W-1:0]  len,
  input  logic [BASE_W-1:0] base,
  input  logic [LIM_W-1:0]  limit,
  input  logic              present,
  input  logic [PW-1:0]     perm,
  output logic [2:0]        err,
  output logic [BASE_W-1:0] pa
);
  logic allowed;
  logic [BASE_W-1:0] sum;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_READ:  allowed = perm[PERM_RD];
      ACC_WRITE: allowed = perm[PERM_WR];
      ACC_FETCH: allowed = perm[PERM_EX];
      default:   allowed = 1'b0;
    endcase
  end

  assign sum = base + BASE_W'(off);

  always_comb begin
    err = ERR_NONE;
    if ({1'b0, seg} >= len)  err = ERR_RANGE;
    else if (!present)       err = ERR_ABSENT;
    else if (off >= limit)   err = ERR_LIMIT;
    else if (!allowed)       err = ERR_PERM;
    pa = (err == ERR_NONE) ? sum : '0;
  end
endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage #(
  parameter int PA_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PA_W-1:0] in_pa,
  input  logic [2:0]      in_err,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PA_W-1:0] out_pa,
  output logic [2:0]      out_err
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pa    <= '0;
      out_err   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_pa    <= in_pa;
      out_err   <= in_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int SEG_W  = 4,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16,
  localparam int LEN_W = SEG_W + 1,
  localparam int PW    = seg_xlate_pkg::PERM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [LIM_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BASE_W-1:0] rsp_pa,
  output logic [2:0]        rsp_err,
  input  logic              cfg_ent_we,
  input  logic [SEG_W-1:0]  cfg_ent_idx,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic              cfg_present,
  input  logic [PW-1:0]     cfg_perm,
  input  logic              cfg_len_we,
  input  logic [LEN_W-1:0]  cfg_len
);
  logic [BASE_W-1:0] ent_base;
  logic [LIM_W-1:0]  ent_limit;
  logic              ent_present;
  logic [PW-1:0]     ent_perm;
  logic [LEN_W-1:0]  len_cur;
  logic [2:0]        chk_err;
  logic [BASE_W-1:0] chk_pa;

  seg_table #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_ent_we), .wr_idx(cfg_ent_idx), .wr_base(cfg_base),
    .wr_limit(cfg_limit), .wr_present(cfg_present), .wr_perm(cfg_perm),
    .len_we(cfg_len_we), .len_d(cfg_len),
    .rd_idx(req_seg), .rd_base(ent_base), .rd_limit(ent_limit),
    .rd_present(ent_present), .rd_perm(ent_perm), .len_q(len_cur)
  );

  seg_check #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_chk_path (
    .seg(req_seg), .off(req_off), .acc(req_acc), .len(len_cur),
    .base(ent_base), .limit(ent_limit), .present(ent_present),
    .perm(ent_perm), .err(chk_err), .pa(chk_pa)
  );

  seg_rsp_stage #(.PA_W(BASE_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_pa(chk_pa), .in_err(chk_err),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_pa(rsp_pa), .out_err(rsp_err)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W  = 4,
  parameter int BASE_W = 24,
  localparam int LEN_W = SEG_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SEG_W-1:0]  req_seg,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BASE_W-1:0] rsp_pa,
  input logic [2:0]        rsp_err,
  input logic [LEN_W-1:0]  len_cur
);
  p_accept_gives_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_ready_tracks_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready));

  p_hold_when_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_err));

  p_range_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_seg} >= len_cur) |=> rsp_err == 3'd1);

  p_fault_zero_pa_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err != 3'd0 |-> rsp_pa == '0);

  p_code_defined_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_err <= 3'd4);
endmodule

bind seg_xlate_unit seg_xlate_chk #(.SEG_W(SEG_W), .BASE_W(BASE_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_seg(req_seg), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_pa(rsp_pa), .rsp_err(rsp_err), .len_cur(len_cur)
);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
  logic clk = 0;
  logic rst_n = 0;
  always #5ns clk = ~clk;

  logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 1;
  logic [3:0] req_seg = 0;
  logic [15:0] req_off = 0;
  logic [1:0] req_acc = 0;
  logic [23:0] rsp_pa;
  logic [2:0] rsp_err;
  logic cfg_ent_we = 0, cfg_present = 0, cfg_len_we = 0;
  logic [3:0] cfg_ent_idx = 0;
  logic [23:0] cfg_base = 0;
  logic [15:0] cfg_limit = 0;
  logic [2:0] cfg_perm = 0;
  logic [4:0] cfg_len = 0;

  seg_xlate_unit i_seg_xlate_unit (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [23:0] m_base [16];
  logic [15:0] m_lim [16];
  logic        m_pres [16];
  logic [2:0]  m_perm [16];
  int          m_len = 0;

  task automatic check(string rq, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_err(int s, int o, int a);
    bit ok;
    ok = (a == 0) ? m_perm[s][0] : (a == 1) ? m_perm[s][1] : (a == 2) ? m_perm[s][2] : 1'b0;
    if (s >= m_len) return 1;
    if (!m_pres[s]) return 2;
    if (o >= m_lim[s]) return 3;
    if (!ok) return 4;
    return 0;
  endfunction

  function automatic int exp_pa(int s, int o, int a);
    logic [23:0] p;
    if (exp_err(s, o, a) != 0) return 0;
    p = m_base[s] + 24'(o);
    return int'(p);
  endfunction

  task automatic set_ent(int i, int b, int l, bit p, int pm);
    @(negedge clk);
    cfg_ent_we = 1; cfg_ent_idx = 4'(i); cfg_base = 24'(b);
    cfg_limit = 16'(l); cfg_present = p; cfg_perm = 3'(pm);
    @(negedge clk);
    cfg_ent_we = 0;
    m_base[i] = 24'(b); m_lim[i] = 16'(l); m_pres[i] = p; m_perm[i] = 3'(pm);
  endtask

  task automatic set_len(int n);
    @(negedge clk);
    cfg_len_we = 1; cfg_len = 5'(n);
    @(negedge clk);
    cfg_len_we = 0; m_len = n;
  endtask

  task automatic xlate(string rq, int s, int o, int a);
    int ee, ep;
    @(negedge clk);
    req_valid = 1; req_seg = 4'(s); req_off = 16'(o); req_acc = 2'(a);
    ee = exp_err(s, o, a); ep = exp_pa(s, o, a);
    @(negedge clk);
    req_valid = 0;
    check({rq, " valid"}, int'(rsp_valid), 1);
    check({rq, " err"}, int'(rsp_err), ee);
    check({rq, " pa"}, int'(rsp_pa), ep);
  endtask

  initial begin
    #2ms;
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int ee, ep, ea, eb;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_pres[i] = 0; m_perm[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 req_ready", int'(req_ready), 1);
    xlate("R1 len zero -> R4 range", 0, 0, 0);
    @(negedge clk);
    check("R2 rsp_valid drops", int'(rsp_valid), 0);

    set_len(3);
    set_ent(0, 'h001000, 'h0100, 1, 3'b111);
    set_ent(1, 'hFFFFF0, 'h0040, 1, 3'b001);
    xlate("R9 basic sum", 0, 'h0042, 0);
    xlate("R9 wrap mod 2^24", 1, 'h0020, 0);
    xlate("R6 off = limit-1 ok", 0, 'h00FF, 2);
    xlate("R6 off = limit", 0, 'h0100, 0);
    xlate("R7 write denied", 1, 4, 1);
    xlate("R7 fetch denied", 1, 4, 2);
    xlate("R7 reserved access", 0, 4, 3);
    xlate("R5 absent", 2, 0, 0);
    xlate("R4 seg = len", 3, 0, 0);
    xlate("R8 range over absent", 9, 'hFFFF, 3);
    xlate("R8 absent over limit", 2, 'hFFFF, 3);
    xlate("R8 limit over perm", 1, 'h0050, 1);
    set_ent(2, 'h0, 0, 1, 3'b111);
    xlate("R6 zero limit", 2, 0, 0);

    // R11 same-cycle write is not seen, next cycle is
    @(negedge clk);
    cfg_ent_we = 1; cfg_ent_idx = 5; cfg_base = 24'h123400; cfg_limit = 16'h10;
    cfg_present = 1; cfg_perm = 3'b010;
    cfg_len_we = 1; cfg_len = 5'd8;
    req_valid = 1; req_seg = 5; req_off = 3; req_acc = 1;
    @(negedge clk);
    cfg_ent_we = 0; cfg_len_we = 0; req_valid = 0;
    check("R11 old length used", int'(rsp_err), 1);
    m_base[5] = 24'h123400; m_lim[5] = 16'h10; m_pres[5] = 1; m_perm[5] = 3'b010; m_len = 8;
    xlate("R11 new entry seen", 5, 3, 1);

    // R3 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_seg = 0; req_off = 16'h10; req_acc = 0;
    ea = exp_pa(0, 'h10, 0);
    @(negedge clk);
    req_seg = 5; req_off = 16'h20; req_acc = 1;
    eb = exp_err(5, 'h20, 1);
    check("R3 req_ready low when stalled", int'(req_ready), 0);
    check("R3 first result", int'(rsp_pa), ea);
    @(negedge clk);
    check("R3 held valid", int'(rsp_valid), 1);
    check("R3 held pa", int'(rsp_pa), ea);
    check("R3 held err", int'(rsp_err), 0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R2 second result after drain", int'(rsp_err), eb);
    check("R10 second pa zero", int'(rsp_pa), 0);
    @(negedge clk);
    check("R2 idle again", int'(rsp_valid), 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r, s, o, a;
      r = $urandom_range(0, 99);
      if (r < 20)
        set_ent($urandom_range(0, 15), $urandom, $urandom_range(0, 300),
                $urandom_range(0, 3) != 0, $urandom_range(0, 7));
      else if (r < 25)
        set_len($urandom_range(0, 16));
      else begin
        s = $urandom_range(0, 15);
        o = (r < 60) ? $urandom_range(0, 320) : $urandom_range(0, 65535);
        a = $urandom_range(0, 3);
        ee = exp_err(s, o, a); ep = exp_pa(s, o, a);
        xlate("R9/R8 random", s, o, a);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule